// File: doc/BRIEF.md
# Selectable Moving-Average and Decimator

This block processes a stream of unsigned 8-bit audio samples, taking one sample on every clock edge. It has two operating modes. In smoothing mode it outputs the mean of a window of strictly earlier samples. In downsampling mode it passes one sample through in every group of M samples and drops the others.

The mode and the window size or decimation factor are captured only while reset is held low. Any change to them during a run has no effect until the next reset. One registered output stage serves both modes. An output-valid strobe marks the cycles that carry a new sample.

Indexing used below: after reset is released, the sample presented at the k-th rising edge (k = 0, 1, ...) is x[k]. "After edge k" means the output values that settle just after that edge.

Top module: `smooth_decim`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge clears `sample_out` to 0, `out_valid` to 0 and all sample history to zero.
- R2: `mode_sel` is captured at every edge where `rst_n` is low. 0 selects smoothing and 1 selects downsampling. Changes to `mode_sel` while `rst_n` is high have no effect.
- R3: `size_sel` is captured with the mode. Code 3'd1 gives size 1, 3'd2 gives size 2 and 3'd4 gives size 4. Every other code behaves as size 1. Changes while `rst_n` is high have no effect.
- R4: In smoothing mode with size N, `sample_out` after edge k equals floor((x[k-N] + ... + x[k-1]) / N). The sample x[k] is not included.
- R5: In smoothing mode, every x[j] with j < 0 counts as zero. Each reset starts a fresh history.
- R6: In smoothing mode, `out_valid` is 1 after every edge from edge 0 onward.
- R7: In downsampling mode with factor M, when k mod M = 0, `sample_out` after edge k equals x[k] and `out_valid` is 1. The first sample after reset is therefore kept.
- R8: In downsampling mode, when k mod M != 0, `out_valid` is 0 and `sample_out` keeps the last kept sample.
- R9: The window sum cannot overflow. A window of four samples of value 255 averages to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one input sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| sample_in | input | 8 | Unsigned input sample |
| mode_sel | input | 1 | 0 = smoothing, 1 = downsampling (captured at reset) |
| size_sel | input | 3 | Window size or decimation factor code (captured at reset) |
| sample_out | output | 8 | Registered output sample |
| out_valid | output | 1 | High when `sample_out` carries a new sample |

## Verification
The assertions check the following on every cycle:
- the cleared state right after reset;
- that the captured configuration stays frozen while running;
- that the valid strobe stays high in smoothing mode;
- that kept samples pass through unchanged and dropped cycles hold the output;
- the exact spacing M between kept samples;
- the one-sample delay of the size-1 window.

The averages for sizes 2 and 4, the zero-filled start of the history, the mapping of illegal size codes, and immunity to mid-run control changes show only in the bench. Its behavioural model compares every output against ramp, alternating, three-value repeating and near-full-scale sequences.

// File: rtl/smooth_decim_pkg.sv
// Package: shared types and helpers for the moving-average / decimator.
// Assumes window sizes and decimation factors are powers of two up to 4.
package smooth_decim_pkg;

    // Operating mode captured at reset.
    typedef enum logic {
        MODE_SMOOTH = 1'b0,
        MODE_DECIM  = 1'b1
    } op_mode_e;

    // Largest supported window / factor and its log2.
    localparam int MAX_WIN     = 4;
    localparam int WIN_SHIFT_W = 2;

    // Map the 3-bit size code to a log2 shift; illegal codes act as size 1.
    function automatic logic [WIN_SHIFT_W-1:0] size_to_shift(input logic [2:0] code);
        logic [WIN_SHIFT_W-1:0] sh;
        case (code)
            3'd2:    sh = 2'd1;
            3'd4:    sh = 2'd2;
            default: sh = 2'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/smooth_decim_cfg.sv
// Module: configuration capture.
// Captures mode and size while reset is held low. Holds both values
// unchanged while running. Assumes a synchronous active-low reset.
module smooth_decim_cfg
    import smooth_decim_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_sel,
    input  logic [2:0]             size_sel,
    output op_mode_e               cfg_mode,
    output logic [WIN_SHIFT_W-1:0] cfg_shift
);

    // Capture configuration on every edge with reset asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode  <= op_mode_e'(mode_sel);
            cfg_shift <= size_to_shift(size_sel);
        end
    end

endmodule

// File: rtl/smooth_decim_hist.sv
// Module: sample history and window mean.
// Keeps the MAX_WIN most recent past samples, zeroed at reset. Forms the
// prefix sums of the taps and divides the selected sum by a right shift.
// Assumes the window length is 1 << shift and never exceeds MAX_WIN.
module smooth_decim_hist #(
    parameter int DATA_W  = 8,
    parameter int MAX_WIN = 4,
    parameter int SHIFT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  sample_in,
    input  logic [SHIFT_W-1:0] shift,
    output logic [DATA_W-1:0]  mean
);

    localparam int SUM_W = DATA_W + $clog2(MAX_WIN);

    logic [DATA_W-1:0] tap_q [MAX_WIN];
    logic [SUM_W-1:0]  psum  [MAX_WIN];
    logic [SUM_W-1:0]  win_sum;
    logic [SUM_W-1:0]  quot;

    // Shift the newest sample into the delay line; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_WIN; i++) tap_q[i] <= '0;
        end else begin
            tap_q[0] <= sample_in;
            for (int i = 1; i < MAX_WIN; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    // Running prefix sums, one adder per tap.
    genvar g;
    generate
        for (g = 0; g < MAX_WIN; g++) begin : g_psum
            if (g == 0) begin : g_first
                assign psum[g] = {{(SUM_W-DATA_W){1'b0}}, tap_q[g]};
            end else begin : g_rest
                assign psum[g] = psum[g-1] + {{(SUM_W-DATA_W){1'b0}}, tap_q[g]};
            end
        end
    endgenerate

    // Pick the prefix sum that covers the active window.
    always_comb begin
        int last;
        last = (1 << shift) - 1;
        if (last > MAX_WIN - 1) last = MAX_WIN - 1;
        win_sum = psum[last];
    end

    // Divide by the window length with a truncating shift.
    assign quot = win_sum >> shift;
    assign mean = quot[DATA_W-1:0];

endmodule

// File: rtl/smooth_decim_phase.sv
// Module: decimation phase counter.
// Counts 0 .. (1 << shift) - 1 and wraps. Flags phase 0 as a keep cycle.
// Assumes it restarts at phase 0 on reset, so the first sample is kept.
module smooth_decim_phase #(
    parameter int CNT_W   = 2,
    parameter int SHIFT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift,
    output logic               keep
);

    logic [CNT_W-1:0] phase_q;
    logic [CNT_W:0]   last_w;

    // Final phase index of one group.
    assign last_w = ({{CNT_W{1'b0}}, 1'b1} << shift) - 1'b1;

    // Advance the phase and wrap at the end of each group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if ({1'b0, phase_q} == last_w) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // A sample is kept on phase zero.
    assign keep = (phase_q == '0);

endmodule

// File: rtl/smooth_decim.sv
// Module: selectable moving-average / decimator top.
// One input sample per clock. The mode and size are captured while rst_n
// is low. A single output register is shared by both modes.
// Assumes unsigned samples and a synchronous active-low reset.
module smooth_decim
    import smooth_decim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              mode_sel,
    input  logic [2:0]        size_sel,
    output logic [DATA_W-1:0] sample_out,
    output logic              out_valid
);

    op_mode_e               cfg_mode;
    logic [WIN_SHIFT_W-1:0] cfg_shift;
    logic [DATA_W-1:0]      mean;
    logic                   keep;

    smooth_decim_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .size_sel  (size_sel),
        .cfg_mode  (cfg_mode),
        .cfg_shift (cfg_shift)
    );

    smooth_decim_hist #(
        .DATA_W  (DATA_W),
        .MAX_WIN (MAX_WIN),
        .SHIFT_W (WIN_SHIFT_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .shift     (cfg_shift),
        .mean      (mean)
    );

    smooth_decim_phase #(
        .CNT_W   (WIN_SHIFT_W),
        .SHIFT_W (WIN_SHIFT_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (cfg_shift),
        .keep  (keep)
    );

    // Shared output register: the mean in smoothing mode, kept samples in decimation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            out_valid  <= 1'b0;
        end else if (cfg_mode == MODE_SMOOTH) begin
            sample_out <= mean;
            out_valid  <= 1'b1;
        end else if (keep) begin
            sample_out <= sample_in;
            out_valid  <= 1'b1;
        end else begin
            out_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/smooth_decim_chk.sv
// Module: property checker for smooth_decim, attached with bind.
// Observes the ports plus the captured configuration.
module smooth_decim_chk
    import smooth_decim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [DATA_W-1:0]      sample_in,
    input logic [DATA_W-1:0]      sample_out,
    input logic                   out_valid,
    input op_mode_e               cfg_mode,
    input logic [WIN_SHIFT_W-1:0] cfg_shift
);

    logic       rst_seen_q;
    logic       seen_q;
    logic [2:0] gap_q;

    // Record that a reset has been applied at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen_q <= 1'b1;
    end

    // Count sampled invalid cycles since the last sampled valid one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (out_valid) begin
            seen_q <= 1'b1;
            gap_q  <= '0;
        end else if (gap_q != 3'd7) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen_q && !$past(rst_n)) |-> (sample_out == '0 && !out_valid));

    p_cfg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_mode) && $stable(cfg_shift)));

    p_unit_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_SMOOTH && cfg_shift == '0 && $past(rst_n) && $past(rst_n, 2))
        |-> (sample_out == $past(sample_in, 2)));

    p_smooth_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_SMOOTH && $past(rst_n)) |-> out_valid);

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_DECIM && out_valid && $past(rst_n))
        |-> (sample_out == $past(sample_in)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_DECIM && !out_valid && $past(rst_n)) |-> $stable(sample_out));

    p_keep_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_DECIM && out_valid && seen_q)
        |-> (gap_q == 3'((1 << cfg_shift) - 1)));

endmodule

bind smooth_decim smooth_decim_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_in  (sample_in),
    .sample_out (sample_out),
    .out_valid  (out_valid),
    .cfg_mode   (cfg_mode),
    .cfg_shift  (cfg_shift)
);

// File: tb/smooth_decim_tb.sv
// Bench: behavioural reference model, compared against the outputs every clock.
module smooth_decim_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sample_in = '0;
    logic       mode_sel = 1'b0;
    logic [2:0] size_sel = 3'd1;
    logic [7:0] sample_out;
    logic       out_valid;

    int n_checks = 0;
    int n_fail   = 0;

    smooth_decim u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .mode_sel   (mode_sel),
        .size_sel   (size_sel),
        .sample_out (sample_out),
        .out_valid  (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Input patterns: ramp, alternating, three-value repeat, near full scale.
    function automatic int gen(input int kind, input int k);
        case (kind)
            0:       return (k + 1) % 256;
            1:       return (k % 2 == 0) ? 2 : 4;
            2:       return (k % 3 == 0) ? 1 : ((k % 3 == 1) ? 5 : 6);
            default: return 250 + (k % 6);
        endcase
    endfunction

    // One scenario: reset with the configuration, then run and compare every cycle.
    task automatic run(input bit mode, input logic [2:0] code, input int kind,
                       input int ncyc, input bit flip);
        int n;
        int xs[$];
        int kept;
        string tag;
        n = (code == 3'd2) ? 2 : ((code == 3'd4) ? 4 : 1);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = mode; size_sel = code; sample_in = 8'hAA;
        @(posedge clk); @(negedge clk);
        check("R1 out", sample_out, 0);
        check("R1 valid", out_valid, 0);
        rst_n = 1'b1;
        kept = 0;
        for (int k = 0; k < ncyc; k++) begin
            sample_in = 8'(gen(kind, k));
            xs.push_back(gen(kind, k));
            if (flip && k == 2) begin
                mode_sel = ~mode;
                size_sel = (code == 3'd2) ? 3'd4 : 3'd2;
            end
            @(posedge clk); @(negedge clk);
            if (!mode) begin
                int acc;
                acc = 0;
                for (int j = 1; j <= n; j++) if (k - j >= 0) acc += xs[k-j];
                tag = flip ? "R2 smooth" : ((code != 3'd1 && code != 3'd2 && code != 3'd4)
                      ? "R3 smooth" : ((k < n) ? "R5 smooth" : ((kind == 3) ? "R9 smooth" : "R4 smooth")));
                check(tag, sample_out, acc / n);
                check("R6 valid", out_valid, 1);
            end else begin
                if (k % n == 0) begin
                    kept = xs[k];
                    tag = flip ? "R2 keep" : ((code != 3'd1 && code != 3'd2 && code != 3'd4) ? "R3 keep" : "R7 keep");
                    check(tag, sample_out, kept);
                    check("R7 valid", out_valid, 1);
                end else begin
                    tag = flip ? "R2 drop" : "R8 drop";
                    check(tag, sample_out, kept);
                    check("R8 valid", out_valid, 0);
                end
            end
        end
        mode_sel = mode; size_sel = code;
    endtask

    // Main sequence of scenarios.
    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 3; s++) begin
                for (int kind = 0; kind < 3; kind++) begin
                    run(m[0], 3'(1 << s), kind, 16, 1'b0);
                end
            end
        end
        run(1'b0, 3'd4, 3, 12, 1'b0);
        run(1'b0, 3'd3, 0, 10, 1'b0);
        run(1'b1, 3'd0, 2, 10, 1'b0);
        run(1'b1, 3'd7, 0, 10, 1'b0);
        run(1'b0, 3'd2, 0, 14, 1'b1);
        run(1'b1, 3'd4, 0, 14, 1'b1);
        run(1'b1, 3'd2, 1, 12, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule